// File: doc/BRIEF.md
# Hardware Register Bitfield Access Unit

This unit runs the scalar instructions that read or modify a run-time selected bitfield of one of a small set of internal 32-bit machine registers. Each accepted instruction brings an opcode and a 16-bit immediate. The immediate packs three things: a register number, the lowest bit of the field, and the field width minus one. A read returns the field, right-aligned and zero-extended, for the destination scalar register. A write merges data from a scalar source value into the field and leaves every other bit of the register unchanged.

A third form of the write takes its data from the 32-bit literal dword that follows the instruction word. A generation-select input chooses which of two opcode numberings is decoded. Opcodes that decode to none of the three forms raise a one-cycle illegal-instruction flag and change nothing.

Six registers can be written: mode, status, exception state, vector register allocation, shared memory allocation and fetch debug. Six more are read-only and take their values from an input vector: unit identity, fetch status, the program counter low and high halves, and the two current instruction dwords.

Top module: `hwreg_field_unit`

## Requirements
- R1: The immediate encodes the register number in bits [5:0], the offset in bits [10:6] and the field size minus one in bits [15:11]. A read returns (reg >> offset) masked to its low size bits, with all upper result bits zero.
- R2: A size of 32 uses an all-ones mask. When offset + size exceeds 32, the field ends at bit 31 for both reads and writes.
- R3: A register write builds mask = ((1 << size) - 1) << offset. The new value is (old & ~mask) | ((src << offset) & mask), so bits outside the mask keep their old values.
- R4: An immediate write records its immediate and raises wait_lit. While wait_lit is high, in_valid is ignored. The write commits, using lit_data, on the first edge where lit_valid is high, and wait_lit then drops.
- R5: With gen_new = 0 the opcodes are read 18, register write 19 and immediate write 21. With gen_new = 1 they are read 17, register write 18 and immediate write 20.
- R6: Register numbers 1 to 6 are writable and map to mode, status, exception, vector alloc, shared alloc and fetch debug. Numbers 7 to 12 are read-only and return ro_vals slices 0 to 5, where slice k is bits [32k+31:32k]. Writes to 7 to 12 are ignored.
- R7: A read of any other register number returns zero, and a write to one is ignored.
- R8: An opcode outside the current set raises illegal for exactly one cycle, with no rd_valid and no register change.
- R9: rd_valid and rd_data appear on the edge after a read is accepted. A write takes effect on the edge where it is accepted, so a read on the next cycle sees it.
- R10: Reset clears the writable registers, rd_valid, illegal and wait_lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_new | input | 1 | Selects the newer opcode numbering |
| in_valid | input | 1 | Instruction word present |
| in_opcode | input | 5 | Instruction opcode |
| in_simm | input | 16 | Packed register number, offset and size minus one |
| in_sdata | input | 32 | Scalar source value for register writes |
| lit_valid | input | 1 | Literal dword present |
| lit_data | input | 32 | Literal dword following the instruction |
| ro_vals | input | 192 | Read-only register values, slice k for register 7+k |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Extracted field |
| illegal | output | 1 | Unrecognised opcode pulse |
| wait_lit | output | 1 | Immediate write waiting for its literal |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 16-bit immediate and a 5-bit opcode. These give offsets up to 31 and sizes up to 32, so the full-width mask and the fields that run past bit 31 can be reached. The 6-bit register number also reaches register 0 and numbers far above 12, which exercises the zero-return path. The reference model predicts every output on every clock from the requirement formulas, using 64-bit arithmetic. Directed corner cases are followed by a seeded random mix of opcodes under both numberings.

// File: rtl/hwf_pkg.sv
package hwf_pkg;
  typedef enum logic [1:0] {
    OPK_READ  = 2'd0,
    OPK_WRITE = 2'd1,
    OPK_WRIMM = 2'd2,
    OPK_BAD   = 2'd3
  } op_kind_t;

  localparam int OLD_OP_READ  = 18;
  localparam int OLD_OP_WRITE = 19;
  localparam int OLD_OP_WRIMM = 21;
  localparam int NEW_OP_READ  = 17;
  localparam int NEW_OP_WRITE = 18;
  localparam int NEW_OP_WRIMM = 20;

  localparam int WR_BASE = 1;
  localparam int N_WR    = 6;
  localparam int RO_BASE = WR_BASE + N_WR;
  localparam int N_RO    = 6;
endpackage

// File: rtl/hwf_decode.sv
module hwf_decode
  import hwf_pkg::*;
#(
  parameter int OPC_W = 5
) (
  input  logic             gen_new,
  input  logic [OPC_W-1:0] opcode,
  output op_kind_t         kind
);
  always_comb begin
    kind = OPK_BAD;
    if (gen_new) begin
      if (opcode == OPC_W'(NEW_OP_READ))       kind = OPK_READ;
      else if (opcode == OPC_W'(NEW_OP_WRITE)) kind = OPK_WRITE;
      else if (opcode == OPC_W'(NEW_OP_WRIMM)) kind = OPK_WRIMM;
    end else begin
      if (opcode == OPC_W'(OLD_OP_READ))       kind = OPK_READ;
      else if (opcode == OPC_W'(OLD_OP_WRITE)) kind = OPK_WRITE;
      else if (opcode == OPC_W'(OLD_OP_WRIMM)) kind = OPK_WRIMM;
    end
  end
endmodule

// File: rtl/hwf_field.sv
module hwf_field #(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src,
  input  logic [OFF_W-1:0]  offset,
  input  logic [OFF_W-1:0]  size_m1,
  output logic [DATA_W-1:0] extracted,
  output logic [DATA_W-1:0] merged
);
  logic [OFF_W:0]      size;
  logic [DATA_W-1:0]   lo_mask;
  logic [DATA_W-1:0]   pos_mask;

  always_comb begin
    size      = {1'b0, size_m1} + 1'b1;
    // a shift by the full width yields zero, so size == DATA_W gives all ones
    lo_mask   = ~({DATA_W{1'b1}} << size);
    pos_mask  = lo_mask << offset;
    extracted = (old_val >> offset) & lo_mask;
    merged    = (old_val & ~pos_mask) | ((src << offset) & pos_mask);
  end
endmodule

// File: rtl/hwf_regbank.sv
module hwf_regbank
  import hwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ID_W-1:0]        sel,
  input  logic                   we,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [N_RO*DATA_W-1:0] ro_vals,
  output logic [DATA_W-1:0]      rdata
);
  logic [DATA_W-1:0] wr_q [N_WR];

  for (genvar g = 0; g < N_WR; g++) begin : g_wr
    always_ff @(posedge clk) begin
      if (rst) wr_q[g] <= '0;
      else if (we && sel == ID_W'(WR_BASE + g)) wr_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_WR; i++)
      if (sel == ID_W'(WR_BASE + i)) rdata = wr_q[i];
    for (int k = 0; k < N_RO; k++)
      if (sel == ID_W'(RO_BASE + k)) rdata = ro_vals[k*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/hwreg_field_unit.sv
module hwreg_field_unit
  import hwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OPC_W  = 5,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int ID_W  = IMM_W - 2*OFF_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   gen_new,
  input  logic                   in_valid,
  input  logic [OPC_W-1:0]       in_opcode,
  input  logic [IMM_W-1:0]       in_simm,
  input  logic [DATA_W-1:0]      in_sdata,
  input  logic                   lit_valid,
  input  logic [DATA_W-1:0]      lit_data,
  input  logic [N_RO*DATA_W-1:0] ro_vals,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   illegal,
  output logic                   wait_lit
);
  op_kind_t          kind;
  logic [IMM_W-1:0]  pend_simm;
  logic [IMM_W-1:0]  cur_simm;
  logic [ID_W-1:0]   cur_id;
  logic [OFF_W-1:0]  cur_off;
  logic [OFF_W-1:0]  cur_szm1;
  logic [DATA_W-1:0] cur_src;
  logic [DATA_W-1:0] old_val;
  logic [DATA_W-1:0] extracted;
  logic [DATA_W-1:0] merged;
  logic              accept;
  logic              we;

  hwf_decode #(.OPC_W(OPC_W)) u_dec (
    .gen_new (gen_new),
    .opcode  (in_opcode),
    .kind    (kind)
  );

  always_comb begin
    accept   = in_valid && !wait_lit;
    cur_simm = wait_lit ? pend_simm : in_simm;
    cur_id   = cur_simm[ID_W-1:0];
    cur_off  = cur_simm[ID_W +: OFF_W];
    cur_szm1 = cur_simm[ID_W+OFF_W +: OFF_W];
    cur_src  = wait_lit ? lit_data : in_sdata;
    we       = (wait_lit && lit_valid) || (accept && kind == OPK_WRITE);
  end

  hwf_regbank #(.DATA_W(DATA_W), .ID_W(ID_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .sel     (cur_id),
    .we      (we),
    .wdata   (merged),
    .ro_vals (ro_vals),
    .rdata   (old_val)
  );

  hwf_field #(.DATA_W(DATA_W)) u_field (
    .old_val   (old_val),
    .src       (cur_src),
    .offset    (cur_off),
    .size_m1   (cur_szm1),
    .extracted (extracted),
    .merged    (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      illegal   <= 1'b0;
      wait_lit  <= 1'b0;
      pend_simm <= '0;
    end else begin
      rd_valid <= 1'b0;
      illegal  <= 1'b0;
      if (wait_lit) begin
        if (lit_valid) wait_lit <= 1'b0;
      end else if (in_valid) begin
        case (kind)
          OPK_READ: begin
            rd_valid <= 1'b1;
            rd_data  <= extracted;
          end
          OPK_WRIMM: begin
            wait_lit  <= 1'b1;
            pend_simm <= in_simm;
          end
          OPK_BAD:   illegal <= 1'b1;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hwreg_field_unit_chk.sv
module hwreg_field_unit_chk
  import hwf_pkg::*;
#(
  parameter int IMM_W  = 16,
  parameter int OPC_W  = 5,
  parameter int DATA_W = 32,
  parameter int ID_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              gen_new,
  input logic              in_valid,
  input logic [OPC_W-1:0]  in_opcode,
  input logic [IMM_W-1:0]  in_simm,
  input logic              lit_valid,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              illegal,
  input logic              wait_lit
);
  logic is_read;
  logic id_unimpl;
  assign is_read   = gen_new ? (in_opcode == OPC_W'(NEW_OP_READ))
                             : (in_opcode == OPC_W'(OLD_OP_READ));
  assign id_unimpl = (in_simm[ID_W-1:0] == '0) ||
                     (in_simm[ID_W-1:0] > ID_W'(RO_BASE + N_RO - 1));

  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, illegal}));

  assert_rd_cause_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(in_valid));

  assert_ill_cause_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(in_valid && !wait_lit));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    wait_lit && !lit_valid |=> wait_lit);

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    wait_lit && lit_valid |=> !wait_lit);

  assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    wait_lit |=> !rd_valid && !illegal);

  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && !wait_lit && is_read && id_unimpl |=> rd_valid && rd_data == '0);
endmodule

bind hwreg_field_unit hwreg_field_unit_chk #(
  .IMM_W(IMM_W), .OPC_W(OPC_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gen_new   (gen_new),
  .in_valid  (in_valid),
  .in_opcode (in_opcode),
  .in_simm   (in_simm),
  .lit_valid (lit_valid),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .illegal   (illegal),
  .wait_lit  (wait_lit)
);

// File: tb/hwreg_field_unit_test.sv
module hwreg_field_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         gen_new = 1'b0;
  logic         in_valid = 1'b0;
  logic [4:0]   in_opcode = '0;
  logic [15:0]  in_simm = '0;
  logic [31:0]  in_sdata = '0;
  logic         lit_valid = 1'b0;
  logic [31:0]  lit_data = '0;
  logic [191:0] ro_vals;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         illegal;
  logic         wait_lit;

  always #5 clk = ~clk;

  hwreg_field_unit uut (
    .clk(clk), .rst(rst), .gen_new(gen_new), .in_valid(in_valid),
    .in_opcode(in_opcode), .in_simm(in_simm), .in_sdata(in_sdata),
    .lit_valid(lit_valid), .lit_data(lit_data), .ro_vals(ro_vals),
    .rd_valid(rd_valid), .rd_data(rd_data), .illegal(illegal),
    .wait_lit(wait_lit)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] mreg [64];
  bit          m_pend;
  logic [15:0] m_simm;
  bit          e_rv, e_ill, e_wait;
  logic [31:0] e_data;
  string       prev_tag = "R10";

  function automatic logic [15:0] mk(int id, int off, int size);
    return {5'(size - 1), 5'(off), 6'(id)};
  endfunction

  // 0 read, 1 write, 2 imm write, 3 illegal (R5)
  function automatic int kind_of(bit g, int op);
    if (g) return (op == 17) ? 0 : (op == 18) ? 1 : (op == 20) ? 2 : 3;
    return (op == 18) ? 0 : (op == 19) ? 1 : (op == 21) ? 2 : 3;
  endfunction

  function automatic logic [31:0] m_read(logic [15:0] s);
    longint v, sz;
    sz = longint'(s[15:11]) + 1;
    v  = longint'(mreg[s[5:0]]) >> s[10:6];
    v  = v & ((64'd1 << sz) - 1);
    return v[31:0];
  endfunction

  task automatic m_write(logic [15:0] s, logic [31:0] d);
    longint mask, sz, nv;
    if (s[5:0] >= 1 && s[5:0] <= 6) begin
      sz   = longint'(s[15:11]) + 1;
      mask = ((64'd1 << sz) - 1) << s[10:6];
      nv   = (longint'(mreg[s[5:0]]) & ~mask) | ((longint'(d) << s[10:6]) & mask);
      mreg[s[5:0]] = nv[31:0];
    end
  endtask

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(rd_valid == e_rv, prev_tag, "rd_valid", rd_valid, e_rv);
    chk(illegal == e_ill, prev_tag, "illegal", illegal, e_ill);
    chk(wait_lit == e_wait, prev_tag, "wait_lit", wait_lit, e_wait);
    if (e_rv) chk(rd_data == e_data, prev_tag, "rd_data", rd_data, e_data);
  endtask

  task automatic step(bit iv, int op, logic [15:0] s, logic [31:0] sd,
                      bit lv, logic [31:0] ld, string tag);
    @(negedge clk);
    compare();
    in_valid = iv; in_opcode = 5'(op); in_simm = s; in_sdata = sd;
    lit_valid = lv; lit_data = ld;
    e_rv = 0; e_ill = 0;
    if (m_pend) begin
      if (lv) begin m_write(m_simm, ld); m_pend = 0; end
    end else if (iv) begin
      case (kind_of(gen_new, op))
        0: begin e_rv = 1; e_data = m_read(s); end
        1: m_write(s, sd);
        2: begin m_pend = 1; m_simm = s; end
        default: e_ill = 1;
      endcase
    end
    e_wait = m_pend;
    prev_tag = tag;
  endtask

  task automatic rd(int id, int off, int sz, string tag);
    step(1, gen_new ? 17 : 18, mk(id, off, sz), 32'h0, 0, 32'h0, tag);
  endtask
  task automatic wr(int id, int off, int sz, logic [31:0] d, string tag);
    step(1, gen_new ? 18 : 19, mk(id, off, sz), d, 0, 32'h0, tag);
  endtask
  task automatic idle(string tag);
    step(0, 0, 16'h0, 32'h0, 0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) ro_vals[k*32 +: 32] = 32'hA5C3_0F10 ^ (32'h1357_9BDF * (k + 1));
    for (int i = 0; i < 64; i++) mreg[i] = '0;
    for (int k = 0; k < 6; k++) mreg[7 + k] = ro_vals[k*32 +: 32];
    m_pend = 0; e_rv = 0; e_ill = 0; e_wait = 0; e_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10: reset state, all writable registers read zero
    for (int id = 1; id <= 6; id++) rd(id, 0, 32, "R10");

    // R1 / R3: field writes and reads on mode
    wr(1, 4, 8, 32'hFFFF_FFAB, "R3");
    rd(1, 0, 32, "R3");
    rd(1, 4, 8, "R1");
    rd(1, 6, 3, "R1");
    wr(1, 0, 4, 32'h5, "R3");
    rd(1, 0, 16, "R9");           // R9: write visible to the very next read
    // R2: full width and truncation at bit 31
    wr(2, 0, 32, 32'hDEAD_BEEF, "R2");
    rd(2, 0, 32, "R2");
    wr(3, 28, 8, 32'hFF, "R2");
    rd(3, 0, 32, "R2");
    rd(2, 28, 8, "R2");
    rd(2, 31, 32, "R2");
    // R6: read-only registers
    for (int id = 7; id <= 12; id++) rd(id, 0, 32, "R6");
    wr(9, 0, 32, 32'h1234_5678, "R6");
    rd(9, 0, 32, "R6");
    rd(12, 8, 12, "R6");
    // R7: unimplemented registers
    wr(0, 0, 32, 32'hFFFF_FFFF, "R7");
    rd(0, 0, 32, "R7");
    wr(40, 3, 10, 32'h3FF, "R7");
    rd(40, 0, 32, "R7");
    rd(13, 0, 32, "R7");
    // R4: immediate write with gaps, instructions ignored while waiting
    step(1, 21, mk(4, 8, 16), 32'h0, 0, 32'h0, "R4");
    rd(4, 0, 32, "R4");
    step(1, 3, 16'h0, 32'h0, 0, 32'h0, "R4");
    idle("R4");
    step(1, 18, mk(4, 0, 32), 32'h0, 1, 32'hCAFE_1234, "R4");
    rd(4, 0, 32, "R4");
    // R8: illegal opcodes leave state untouched
    step(1, 5, mk(1, 0, 32), 32'hFFFF_FFFF, 0, 32'h0, "R8");
    step(1, 20, mk(1, 0, 32), 32'hFFFF_FFFF, 0, 32'h0, "R8");
    rd(1, 0, 32, "R8");
    // R5: newer numbering
    @(negedge clk); compare(); in_valid = 0; e_rv = 0; e_ill = 0; gen_new = 1'b1;
    prev_tag = "R5";
    rd(1, 0, 32, "R5");
    wr(5, 12, 6, 32'h2A, "R5");
    rd(5, 12, 6, "R5");
    step(1, 19, mk(5, 0, 32), 32'hFFFF_FFFF, 0, 32'h0, "R5");
    step(1, 21, mk(5, 0, 32), 32'h0, 0, 32'h0, "R5");
    step(1, 20, mk(6, 16, 16), 32'h0, 0, 32'h0, "R5");
    step(0, 0, 16'h0, 32'h0, 1, 32'h0000_BEEF, "R5");
    rd(6, 0, 32, "R5");
    rd(5, 0, 32, "R5");
    // mixed random traffic under both numberings
    for (int n = 0; n < 600; n++) begin
      int op, id;
      if (n % 150 == 0) begin
        @(negedge clk); compare(); in_valid = 0; lit_valid = 0;
        e_rv = 0; e_ill = 0; gen_new = ~gen_new; prev_tag = "R5";
      end
      op = 16 + int'($urandom_range(0, 6));
      id = int'($urandom_range(0, 15));
      step(($urandom_range(0, 3) != 0), op,
           {5'($urandom), 5'($urandom), 6'(id)}, $urandom,
           ($urandom_range(0, 2) == 0), $urandom, "R3");
    end
    idle("R9");
    idle("R9");
    @(negedge clk); compare();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule